// File: doc/BRIEF.md
# Power-up and brown-out startup sequencer

This block is the startup state machine of a peak current-mode PWM controller. It watches three comparator flags: the supply is above its turn-on level, the line-sense input is above its brown-out level, and the soft-start ramp has finished. From these it decides when the soft-start capacitor may be released from ground and when the power stage may switch. The analog current sources, the capacitor and the PWM generator sit outside it. It reads only the comparator flags and drives only the control lines listed below.

A start that comes from the supply goes through an internal wait before soft-start may begin. The wait lets an upstream pre-regulator settle. When the line-sense input drops below its level, the controller stops switching and stays off. This happens both on a real line sag and when an external transistor pulls the pin low to shut the controller down. When the input comes back, a fresh soft-start begins at once, without the wait. A build parameter removes the wait for the variant that has none. The block also drives an enable for the current sink that gives the line-sense comparator its hysteresis. A `steady` output tells downstream logic that soft-start has finished.

Top module: `startup_sequencer`

## Requirements
- R1: After reset, and whenever the supply flag is low, `ss_clamp` is 1 and `sw_en`, `steady` and `bo_sink_en` are 0. `ss_clamp` and `sw_en` are never both 1 or both 0.
- R2: With `HAS_DELAY`=1, the first rising edge that samples `vcc_ok`=1 starts a wait. During the wait `sw_en` stays 0 and `ss_clamp` stays 1. If `bo_ok` is 1 at the end, `sw_en` becomes 1 after rising edge number `DELAY_CYCLES`+1 counted from that first edge.
- R3: If `bo_ok` is 0 when the wait ends, the clamp stays on. Soft-start (`sw_en`=1, `ss_clamp`=0) begins right after the first rising edge that samples `bo_ok`=1.
- R4: In soft-start or steady operation, a rising edge that samples `bo_ok`=0 sets `sw_en` to 0, `ss_clamp` to 1 and `steady` to 0 right after that edge.
- R5: After a brown-out stop, the first edge that samples `bo_ok`=1 with the supply up starts soft-start at once, with no wait. `steady` is 0 at that point.
- R6: During soft-start, an edge that samples `ss_done`=1 sets `steady` to 1. `sw_en` stays 1. `steady` stays 1 until the supply or the line-sense input is lost.
- R7: An edge that samples `vcc_ok`=0 returns the block to the off state in any state. The next supply rise runs the full wait again, even if an earlier wait was cut short.
- R8: `bo_sink_en` equals `vcc_ok`=1 AND `bo_ok`=0 as sampled at the previous rising edge.
- R9: With `HAS_DELAY`=0, the first edge that samples `vcc_ok`=1 with `bo_ok`=1 starts soft-start directly.
- R10: The level of `bo_ok` during the wait does not shorten, restart or extend it. Only its level at the end decides between soft-start and waiting for the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_ok | input | 1 | Supply above turn-on level (synchronous) |
| bo_ok | input | 1 | Line-sense input above brown-out level (synchronous) |
| ss_done | input | 1 | Soft-start ramp has reached its end level |
| ss_clamp | output | 1 | Hold the soft-start capacitor at ground |
| sw_en | output | 1 | Allow the PWM stage to switch |
| steady | output | 1 | Soft-start finished, steady operation |
| bo_sink_en | output | 1 | Enable the hysteresis current sink on the line-sense pin |

## Verification
The bench builds two copies side by side. One has `HAS_DELAY`=1 and a short `DELAY_CYCLES` of 12. The other has `HAS_DELAY`=0. Both are driven by the same inputs. The short wait lets the bench reach the exact edge where the wait ends many times in a run. It can also cut the wait short with a supply drop and toggle the line-sense input inside it. Meanwhile the no-wait copy covers the direct start path and its own brown-out recoveries under the same traffic.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    typedef enum logic [2:0] {
        SU_OFF       = 3'd0,
        SU_DELAY     = 3'd1,
        SU_WAIT_BO   = 3'd2,
        SU_SOFTSTART = 3'd3,
        SU_RUN       = 3'd4
    } su_state_e;

    typedef struct packed {
        su_state_e state;
    } su_fsm_t;

    typedef struct packed {
        logic sink;
    } su_sink_t;

endpackage

// File: rtl/su_delay_timer.sv
module su_delay_timer #(
    parameter int HAS_DELAY    = 1,
    parameter int DELAY_CYCLES = 12_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int DW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES + 1) : 1;
    localparam logic [DW-1:0] LAST = DW'(DELAY_CYCLES - 1);

    generate
        if (HAS_DELAY != 0) begin : g_timer
            typedef struct packed {
                logic [DW-1:0] cnt;
            } tmr_t;

            tmr_t tmr_d, tmr_q;

            always_comb begin
                tmr_d = tmr_q;
                if (run && (tmr_q.cnt != LAST)) begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end else begin
                    tmr_d.cnt = '0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tmr_q <= '0;
                end else begin
                    tmr_q <= tmr_d;
                end
            end

            assign done = run && (tmr_q.cnt == LAST);
        end else begin : g_no_timer
            logic unused_run;
            assign unused_run = run;
            assign done = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/su_fsm.sv
module su_fsm
    import startup_seq_pkg::*;
#(
    parameter int HAS_DELAY = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vcc_ok,
    input  logic      bo_ok,
    input  logic      ss_done,
    input  logic      dly_done,
    output su_state_e state_q,
    output logic      dly_run
);
    su_fsm_t fsm_d, fsm_q;

    // Where a finished or skipped wait leads, set by the line-sense level.
    function automatic su_state_e after_wait(input logic bo);
        return bo ? SU_SOFTSTART : SU_WAIT_BO;
    endfunction

    always_comb begin
        fsm_d = fsm_q;
        if (!vcc_ok) begin
            fsm_d.state = SU_OFF;
        end else begin
            unique case (fsm_q.state)
                SU_OFF: begin
                    if (HAS_DELAY != 0) begin
                        fsm_d.state = SU_DELAY;
                    end else begin
                        fsm_d.state = after_wait(bo_ok);
                    end
                end
                SU_DELAY: begin
                    if (dly_done) begin
                        fsm_d.state = after_wait(bo_ok);
                    end
                end
                SU_WAIT_BO: begin
                    if (bo_ok) begin
                        fsm_d.state = SU_SOFTSTART;
                    end
                end
                SU_SOFTSTART: begin
                    if (!bo_ok) begin
                        fsm_d.state = SU_WAIT_BO;
                    end else if (ss_done) begin
                        fsm_d.state = SU_RUN;
                    end
                end
                SU_RUN: begin
                    if (!bo_ok) begin
                        fsm_d.state = SU_WAIT_BO;
                    end
                end
                default: fsm_d.state = SU_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= SU_OFF;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_q = fsm_q.state;
    assign dly_run = (fsm_q.state == SU_DELAY);
endmodule

// File: rtl/su_outputs.sv
module su_outputs
    import startup_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  su_state_e state_q,
    input  logic      vcc_ok,
    input  logic      bo_ok,
    output logic      ss_clamp,
    output logic      sw_en,
    output logic      steady,
    output logic      bo_sink_en
);
    su_sink_t snk_d, snk_q;

    always_comb begin
        snk_d      = snk_q;
        snk_d.sink = vcc_ok && !bo_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snk_q <= '0;
        end else begin
            snk_q <= snk_d;
        end
    end

    always_comb begin
        sw_en  = (state_q == SU_SOFTSTART) || (state_q == SU_RUN);
        steady = (state_q == SU_RUN);
    end

    assign ss_clamp   = !sw_en;
    assign bo_sink_en = snk_q.sink;
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import startup_seq_pkg::*;
#(
    parameter int HAS_DELAY    = 1,
    parameter int DELAY_CYCLES = 12_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic bo_ok,
    input  logic ss_done,
    output logic ss_clamp,
    output logic sw_en,
    output logic steady,
    output logic bo_sink_en
);
    su_state_e state_q;
    logic      dly_run;
    logic      dly_done;

    su_delay_timer #(
        .HAS_DELAY   (HAS_DELAY),
        .DELAY_CYCLES(DELAY_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (dly_run),
        .done (dly_done)
    );

    su_fsm #(
        .HAS_DELAY(HAS_DELAY)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .vcc_ok  (vcc_ok),
        .bo_ok   (bo_ok),
        .ss_done (ss_done),
        .dly_done(dly_done),
        .state_q (state_q),
        .dly_run (dly_run)
    );

    su_outputs u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .vcc_ok    (vcc_ok),
        .bo_ok     (bo_ok),
        .ss_clamp  (ss_clamp),
        .sw_en     (sw_en),
        .steady    (steady),
        .bo_sink_en(bo_sink_en)
    );
endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk
    import startup_seq_pkg::*;
#(
    parameter int HAS_DELAY    = 1,
    parameter int DELAY_CYCLES = 12_000_000
) (
    input logic      clk,
    input logic      rst_n,
    input logic      vcc_ok,
    input logic      bo_ok,
    input logic      ss_done,
    input logic      ss_clamp,
    input logic      sw_en,
    input logic      steady,
    input logic      bo_sink_en,
    input su_state_e state_q
);
    localparam int CW = $clog2(DELAY_CYCLES + 2);

    // Cycles already spent in the wait state.
    logic [CW-1:0] dwell_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else if (state_q == SU_DELAY) begin
            dwell_q <= dwell_q + 1'b1;
        end else begin
            dwell_q <= '0;
        end
    end

    assert_clamp_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_clamp != sw_en);

    assert_delay_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SU_DELAY) |-> (dwell_q < CW'(DELAY_CYCLES)));

    assert_bo_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bo_ok |=> (!sw_en && !steady));

    assert_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SU_WAIT_BO && vcc_ok && bo_ok) |=> (sw_en && !steady));

    assert_steady_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steady) |-> ($past(ss_done) && $past(state_q) == SU_SOFTSTART));

    assert_supply_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (state_q == SU_OFF && ss_clamp && !bo_sink_en));

    assert_sink_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && !bo_ok) |=> bo_sink_en);

    assert_sink_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(vcc_ok && !bo_ok) |=> !bo_sink_en);

    generate
        if (HAS_DELAY == 0) begin : g_nd
            assert_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
                state_q != SU_DELAY);
        end else begin : g_d
            assert_wait_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == SU_OFF && vcc_ok) |=> (state_q == SU_DELAY));
        end
    endgenerate
endmodule

bind startup_sequencer startup_sequencer_chk #(
    .HAS_DELAY   (HAS_DELAY),
    .DELAY_CYCLES(DELAY_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vcc_ok    (vcc_ok),
    .bo_ok     (bo_ok),
    .ss_done   (ss_done),
    .ss_clamp  (ss_clamp),
    .sw_en     (sw_en),
    .steady    (steady),
    .bo_sink_en(bo_sink_en),
    .state_q   (state_q)
);

// File: tb/startup_sequencer_bench.sv
`timescale 1ns/1ps
module startup_sequencer_bench;
    localparam int N = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok = 1'b0;
    logic bo_ok = 1'b0;
    logic ss_done = 1'b0;

    logic a_clamp, a_sw, a_steady, a_sink;
    logic b_clamp, b_sw, b_steady, b_sink;

    int checks = 0;
    int errors = 0;
    bit auto_on = 1'b0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    startup_sequencer #(.HAS_DELAY(1), .DELAY_CYCLES(N)) u_startup_sequencer (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .bo_ok(bo_ok), .ss_done(ss_done),
        .ss_clamp(a_clamp), .sw_en(a_sw), .steady(a_steady), .bo_sink_en(a_sink));

    startup_sequencer #(.HAS_DELAY(0), .DELAY_CYCLES(N)) u_startup_sequencer_nd (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .bo_ok(bo_ok), .ss_done(ss_done),
        .ss_clamp(b_clamp), .sw_en(b_sw), .steady(b_steady), .bo_sink_en(b_sink));

    // Reference model states: 0 off, 1 wait, 2 line wait, 3 soft-start, 4 steady.
    function automatic int m_next(int st, int cnt, bit vcc, bit bo, bit ssd, bit hd);
        if (!vcc) return 0;
        case (st)
            0: return hd ? 1 : (bo ? 3 : 2);
            1: return (cnt == N - 1) ? (bo ? 3 : 2) : 1;
            2: return bo ? 3 : 2;
            3: return !bo ? 2 : (ssd ? 4 : 3);
            default: return bo ? 4 : 2;
        endcase
    endfunction

    function automatic int m_cnt(int st, int cnt);
        return (st == 1 && cnt != N - 1) ? cnt + 1 : 0;
    endfunction

    int ma_st = 0, ma_cnt = 0, mb_st = 0;
    bit m_sink = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ma_st <= 0; ma_cnt <= 0; mb_st <= 0; m_sink <= 1'b0;
        end else begin
            ma_st  <= m_next(ma_st, ma_cnt, vcc_ok, bo_ok, ss_done, 1'b1);
            ma_cnt <= m_cnt(ma_st, ma_cnt);
            mb_st  <= m_next(mb_st, 0, vcc_ok, bo_ok, ss_done, 1'b0);
            m_sink <= vcc_ok & ~bo_ok;
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (auto_on && !done_flag) begin
            chk("R2", "a.clamp", a_clamp, ma_st <= 2);
            chk("R4", "a.sw_en", a_sw, ma_st >= 3);
            chk("R6", "a.steady", a_steady, ma_st == 4);
            chk("R8", "a.sink", a_sink, m_sink);
            chk("R9", "b.sw_en", b_sw, mb_st >= 3);
            chk("R6", "b.steady", b_steady, mb_st == 4);
            chk("R8", "b.sink", b_sink, m_sink);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd7321);
        @(negedge clk);
        step(2);
        // R1 reset state
        chk("R1", "clamp", a_clamp, 1'b1);
        chk("R1", "sw_en", a_sw, 1'b0);
        chk("R1", "steady", a_steady, 1'b0);
        chk("R1", "sink", a_sink, 1'b0);
        chk("R1", "b.clamp", b_clamp, 1'b1);
        rst_n = 1'b1;
        auto_on = 1'b1;
        step(2);
        chk("R1", "idle clamp", a_clamp, 1'b1);

        // R2, R9, R10: supply up, line toggled inside the wait
        vcc_ok = 1'b1; bo_ok = 1'b1;
        step(1);
        chk("R2", "wait sw_en", a_sw, 1'b0);
        chk("R9", "direct sw_en", b_sw, 1'b1);
        bo_ok = 1'b0;
        step(4);
        chk("R10", "wait sw_en bo low", a_sw, 1'b0);
        bo_ok = 1'b1;
        for (int k = 6; k <= N; k++) begin
            step(1);
            chk("R2", "wait clamp", a_clamp, 1'b1);
        end
        step(1);
        chk("R10", "end of wait sw_en", a_sw, 1'b1);
        chk("R2", "end of wait clamp", a_clamp, 1'b0);

        // R6
        ss_done = 1'b1;
        step(1);
        chk("R6", "steady", a_steady, 1'b1);
        ss_done = 1'b0;
        step(2);
        chk("R6", "steady held", a_steady, 1'b1);
        chk("R6", "sw held", a_sw, 1'b1);

        // R4, R8, R5
        bo_ok = 1'b0;
        step(1);
        chk("R4", "sw off", a_sw, 1'b0);
        chk("R4", "clamp on", a_clamp, 1'b1);
        chk("R4", "steady off", a_steady, 1'b0);
        chk("R8", "sink on", a_sink, 1'b1);
        step(3);
        chk("R4", "stays off", a_sw, 1'b0);
        bo_ok = 1'b1;
        step(1);
        chk("R5", "restart sw", a_sw, 1'b1);
        chk("R5", "restart not steady", a_steady, 1'b0);
        chk("R8", "sink off", a_sink, 1'b0);

        // R7: supply loss, then a wait cut short must restart in full
        vcc_ok = 1'b0;
        step(1);
        chk("R7", "off clamp", a_clamp, 1'b1);
        chk("R7", "off sw", a_sw, 1'b0);
        vcc_ok = 1'b1;
        step(5);
        vcc_ok = 1'b0;
        step(1);
        vcc_ok = 1'b1;
        step(N);
        chk("R7", "full wait again", a_sw, 1'b0);
        step(1);
        chk("R7", "wait end", a_sw, 1'b1);

        // R3: wait ends with line low
        vcc_ok = 1'b0;
        step(1);
        vcc_ok = 1'b1; bo_ok = 1'b0;
        step(N + 3);
        chk("R3", "held after wait", a_sw, 1'b0);
        chk("R3", "clamp after wait", a_clamp, 1'b1);
        bo_ok = 1'b1;
        step(1);
        chk("R3", "soft-start on line", a_sw, 1'b1);

        // Constrained random traffic checked against the model
        for (int c = 0; c < 6000; c++) begin
            if (($urandom() % 96) == 0) vcc_ok = ~vcc_ok;
            else if (!vcc_ok && ($urandom() % 4) == 0) vcc_ok = 1'b1;
            if (($urandom() % 20) == 0) bo_ok = ~bo_ok;
            ss_done = (($urandom() % 8) == 0);
            step(1);
        end

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule